// File: doc/BRIEF.md
# Configurable Galois Pattern Generator

This block produces pseudo-random test patterns for built-in self-test. It is a shift register of parameterised width whose feedback is applied in the one-to-many (Galois) arrangement. Each step shifts the state one place toward bit 0. The bit that leaves at bit 0 is folded into every stage selected by a tap mask, in that same clock. The tap mask and the seed are run-time inputs. A mode pin selects XOR or XNOR feedback.

A controller loads a seed, then raises the step enable for as many cycles as it needs patterns. The whole state word is visible every cycle, together with its low bit as a serial stream. A flag reports when the register sits in the state it can never leave under the current mode. The load path refuses to enter that state: if the seed equals the lock-up pattern, a fixed legal default is loaded instead.

Top module: `galois_prpg`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the state to DEFAULT_SEED (0x0001 by default), whatever load and step_en are doing.
- R2: When rst is low and load is high, the state takes seed_i at that edge. Load wins over step_en.
- R3: If a loaded seed equals the lock-up pattern of the current mode (all zeros for XOR, all ones for XNOR), DEFAULT_SEED is loaded instead.
- R4: With rst, load and step_en all low, the state holds its value.
- R5: XOR mode (mode_xnor_i = 0), step: let o = state[0]. The next state is (state >> 1) with a 0 filled into the top bit, then XORed with taps_i wherever o = 1. Bit i of taps_i selects stage i.
- R6: XNOR mode (mode_xnor_i = 1), step: the top bit is filled with 1. Each tapped stage i takes the XNOR of the shifted bit and o, and untapped stages take the shifted bit unchanged.
- R7: serial_o always equals state bit 0.
- R8: lockup_o is high exactly when the state equals the lock-up pattern of the mode currently selected, and it follows a change of mode without a clock.
- R9: A register in its lock-up state stays there while stepping in that mode.
- R10: With the 16-bit tap mask 0xB400 in XOR mode, the state returns to its start after exactly 65535 steps, and each step matches a software model.
- R11: With a non-maximal mask (0x8000), the period equals the one the software model predicts (16), in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register one step |
| load | input | 1 | Load seed_i (guarded) |
| mode_xnor_i | input | 1 | 0 selects XOR feedback, 1 selects XNOR feedback |
| seed_i | input | WIDTH | Seed word |
| taps_i | input | WIDTH | Tap mask; bit i feeds stage i |
| state_o | output | WIDTH | Current state |
| serial_o | output | 1 | State bit 0 |
| lockup_o | output | 1 | State equals the lock-up pattern of the current mode |

## Verification
Load and step can be requested in the same cycle, and so can reset and load. Vectors in the stimulus table raise these pairs together. The state after that edge must be the seed in the first case and DEFAULT_SEED in the second, never the stepped value. A load of the lock-up pattern is also combined with a mode change. This checks that both the guard and the flag judge the lock-up pattern by the mode in force on that cycle.

// File: rtl/prpg_pkg.sv
package prpg_pkg;

  typedef enum logic {
    FB_XOR  = 1'b0,
    FB_XNOR = 1'b1
  } fb_mode_e;

  // Value shifted into the top stage and the pattern the register cannot leave
  function automatic logic fill_bit(input fb_mode_e m);
    return (m == FB_XNOR);
  endfunction

endpackage

// File: rtl/prpg_galois_next.sv
module prpg_galois_next
  import prpg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] taps_i,
  input  fb_mode_e         mode_i,
  output logic [WIDTH-1:0] nxt_o
);

  logic             out_bit;
  logic [WIDTH-1:0] shifted;
  logic             inj;

  assign out_bit = cur_i[0];
  assign shifted = {fill_bit(mode_i), cur_i[WIDTH-1:1]};
  // XNOR(a, o) == a ^ o ^ 1, so one gate per tapped stage either way
  assign inj     = out_bit ^ fill_bit(mode_i);

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    assign nxt_o[g] = taps_i[g] ? (shifted[g] ^ inj) : shifted[g];
  end

endmodule

// File: rtl/prpg_lock_detect.sv
module prpg_lock_detect
  import prpg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] state_i,
  input  fb_mode_e         mode_i,
  output logic [WIDTH-1:0] lock_pat_o,
  output logic             locked_o
);

  assign lock_pat_o = {WIDTH{fill_bit(mode_i)}};
  assign locked_o   = (state_i == lock_pat_o);

endmodule

// File: rtl/prpg_seed_guard.sv
module prpg_seed_guard #(
  parameter int               WIDTH        = 16,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] lock_pat_i,
  output logic [WIDTH-1:0] safe_o
);

  assign safe_o = (seed_i == lock_pat_i) ? DEFAULT_SEED : seed_i;

endmodule

// File: rtl/galois_prpg.sv
module galois_prpg
  import prpg_pkg::*;
#(
  parameter int               WIDTH        = 16,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             load,
  input  logic             mode_xnor_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] taps_i,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o,
  output logic             lockup_o
);

  fb_mode_e         mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] lock_pat;
  logic [WIDTH-1:0] load_val;

  assign mode = fb_mode_e'(mode_xnor_i);

  prpg_galois_next #(.WIDTH(WIDTH)) u_next (
    .cur_i  (state_q),
    .taps_i (taps_i),
    .mode_i (mode),
    .nxt_o  (step_val)
  );

  prpg_lock_detect #(.WIDTH(WIDTH)) u_lock (
    .state_i    (state_q),
    .mode_i     (mode),
    .lock_pat_o (lock_pat),
    .locked_o   (lockup_o)
  );

  prpg_seed_guard #(.WIDTH(WIDTH), .DEFAULT_SEED(DEFAULT_SEED)) u_guard (
    .seed_i     (seed_i),
    .lock_pat_i (lock_pat),
    .safe_o     (load_val)
  );

  always_ff @(posedge clk) begin
    if (rst)          state_q <= DEFAULT_SEED;
    else if (load)    state_q <= load_val;
    else if (step_en) state_q <= step_val;
  end

  assign state_o  = state_q;
  assign serial_o = state_q[0];

  // R1: the cycle after reset holds the default seed
  p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == DEFAULT_SEED);

  // R2: a legal seed is taken as is, even with step_en high
  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    (load && seed_i != lock_pat) |=> state_q == $past(seed_i));

  // R3: a lock-up seed is replaced by the default
  p_lock_subst_r3: assert property (@(posedge clk) disable iff (rst)
    (load && seed_i == lock_pat) |=> state_q == DEFAULT_SEED);

  // R4: idle cycles keep the state
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(state_q));

  // R9: lock-up is absorbing under stepping in the same mode
  p_lock_stuck_r9: assert property (@(posedge clk) disable iff (rst)
    (lockup_o && !load) |=> $stable(state_q));

endmodule

// File: tb/sim_galois_prpg.sv
module sim_galois_prpg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic         rst;
    logic         load;
    logic         en;
    logic         mode;
    logic [W-1:0] seed;
    logic [W-1:0] taps;
    logic [W-1:0] exp_state;
    logic         exp_lock;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hB400, 16'h0001, 1'b0}, // R1 reset
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hB400, 16'hB400, 1'b0}, // R5 out=1
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hB400, 16'h5A00, 1'b0}, // R5 out=0
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hB400, 16'h2D00, 1'b0}, // R5
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'hB400, 16'h0001, 1'b0}, // R3 zero seed
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h8001, 16'hB400, 16'h8001, 1'b0}, // R2 load over step
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hB400, 16'hF400, 1'b0}, // R5
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hB400, 16'hF400, 1'b0}, // R4 hold
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, 16'hB400, 16'h0001, 1'b0}, // R3 ones in XNOR
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'hB400, 16'h8000, 1'b0}, // R6 out=1
    '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'hB400, 16'h7400, 1'b0}, // R6 out=0
    '{1'b1, 1'b1, 1'b1, 1'b1, 16'h1234, 16'hB400, 16'h0001, 1'b0}, // R1 reset over load
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hB400, 16'h0000, 1'b0}, // R2 zero legal in XNOR
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hB400, 16'h0000, 1'b1}, // R8 flag follows mode
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hB400, 16'h0000, 1'b1}, // R9 stuck
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hB400, 16'h0000, 1'b0}  // R8
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic         load = 1'b0;
  logic         mode_xnor = 1'b0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] taps = 16'hB400;
  logic [W-1:0] state;
  logic         serial, lockup;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  galois_prpg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .load(load),
    .mode_xnor_i(mode_xnor), .seed_i(seed), .taps_i(taps),
    .state_o(state), .serial_o(serial), .lockup_o(lockup)
  );

  function automatic logic [W-1:0] model_step(logic [W-1:0] s, logic [W-1:0] t, logic m);
    logic [W-1:0] sh, r;
    sh = {m, s[W-1:1]};
    for (int i = 0; i < W; i++) r[i] = t[i] ? ~(sh[i] ^ s[0] ^ ~m) : sh[i];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Loads start_val, steps until the state returns; also tracks the model
  task automatic measure(string req, logic m, logic [W-1:0] t, logic [W-1:0] start_val, int exp_period);
    logic [W-1:0] mdl;
    int n;
    int bad;
    mode_xnor = m; taps = t; seed = start_val; load = 1'b1; step_en = 1'b0;
    tick();
    load = 1'b0; step_en = 1'b1;
    mdl = start_val; n = 0; bad = 0;
    do begin
      tick();
      mdl = model_step(mdl, t, m);
      if (state !== mdl) bad++;
      n++;
    end while (state !== start_val && n < 70000);
    step_en = 1'b0;
    check({req, " model match"}, W'(bad), '0);
    check({req, " period"}, W'(n), W'(exp_period));
  endtask

  initial begin
    @(negedge clk);
    foreach (VECS[k]) begin
      rst = VECS[k].rst; load = VECS[k].load; step_en = VECS[k].en;
      mode_xnor = VECS[k].mode; seed = VECS[k].seed; taps = VECS[k].taps;
      tick();
      check($sformatf("vec%0d state R1/R2/R3/R4/R5/R6/R9", k), state, VECS[k].exp_state);
      check($sformatf("vec%0d lockup R8", k), W'(lockup), W'(VECS[k].exp_lock));
      check($sformatf("vec%0d serial R7", k), W'(serial), W'(state[0]));
    end
    rst = 1'b0; load = 1'b0; step_en = 1'b0;

    // R8/R9: all ones is legal in XOR, lock-up in XNOR
    mode_xnor = 1'b0; seed = 16'hFFFF; load = 1'b1;
    tick();
    load = 1'b0;
    check("R8 ones in XOR not locked", W'(lockup), 16'h0000);
    mode_xnor = 1'b1; step_en = 1'b1;
    #1;
    check("R8 ones in XNOR locked", W'(lockup), 16'h0001);
    tick(); tick();
    step_en = 1'b0;
    check("R9 XNOR lock-up persists", state, 16'hFFFF);

    // R10: full period, R11: short periods
    measure("R10 maximal XOR", 1'b0, 16'hB400, 16'h0001, 65535);
    measure("R11 short XOR", 1'b0, 16'h8000, 16'h0001, 16);
    measure("R11 short XNOR", 1'b1, 16'h8000, 16'h0001, 16);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule